// File: doc/BRIEF.md
# Parallel Streaming BCH Encoder

This block is a systematic binary BCH encoder for a packet stream that carries `DW` bits per beat. A source offers a message as `MSG_BITS / DW` beats framed by start and end marks. The block forwards each message beat unchanged to its output register. While doing so, it divides the message by the generator polynomial in a parallel LFSR that absorbs `DW` bits per clock. Once the message is complete, it appends the `PAR_BITS` remainder bits as further beats. The output stream carries its own start and end marks and stalls whenever the sink withholds `out_ready`.

Codeword length, message length, beat width and generator polynomial are all fixed at elaboration. A shortened code is obtained by choosing `MSG_BITS + PAR_BITS` below the natural length `2^m - 1`. The leading message bits that are absent count as zeros, they are never sent, and the parity width does not change. The default build is a (14,6) code shortened from the length-15 two-error-correcting code with g(x) = x^8+x^7+x^6+x^4+1, at two bits per beat.

Top module: `bch_stream_enc`

## Requirements
- R1: Message beats appear on `out_data` unchanged and in arrival order. Within every beat, bit `DW-1` is the earliest bit of the codeword, i.e. the highest-degree coefficient.
- R2: The `PAR_BITS/DW` beats that follow the message carry the remainder of m(x)·x^PAR_BITS divided by g(x), coefficient x^(PAR_BITS-1) first. Every emitted codeword, including those of the shortened length, is a multiple of g(x).
- R3: `in_ready` equals "output register free" (`out_valid` low or `out_ready` high) while idle or while a message still lacks at least two beats. It is low once all but the last message beat have been taken, and it stays low until the final parity beat has been loaded. The last message beat, which the source marks with `in_eop`, is taken on the first edge where it is offered while the output register is free.
- R4: `out_sop` is high on the first message beat of a codeword only. `out_eop` is high on the last parity beat only.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values.
- R6: While idle, an offered beat with `in_sop` low is consumed (`in_ready` high) and discarded, and no output beat results.
- R7: The remainder restarts from zero on every accepted start beat, so consecutive packets, including ones with no idle cycle between them, are encoded independently.
- R8: During and after a synchronous active-high `rst`, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source offers a beat |
| in_ready | output | 1 | Block will take a non-final beat this cycle |
| in_sop | input | 1 | Offered beat is the first of a message |
| in_eop | input | 1 | Offered beat is the last of a message |
| in_data | input | DW | Message bits, earliest bit in the MSB |
| out_valid | output | 1 | Output register holds a beat |
| out_ready | input | 1 | Sink takes the output beat this cycle |
| out_sop | output | 1 | Output beat is the first of a codeword |
| out_eop | output | 1 | Output beat is the last of a codeword |
| out_data | output | DW | Codeword bits, earliest bit in the MSB |

## Verification
Two events can coincide in one cycle. The last parity beat of one codeword can leave the output register on the same edge that the start beat of the next message is captured and the remainder is reloaded from zero. The bench provokes this by queueing packets with no gap and holding both valid and ready high, and by mixing random gaps with random sink stalls. A correct result shows an `out_sop` beat directly after the `out_eop` beat, with parity equal to the bench's own serial division of the new message. The bench also checks every received codeword for divisibility by g(x).

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;
  // Framing phase of the encoder
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // waiting for a start beat
    PH_MSG  = 2'd1,  // message beats being taken
    PH_PAR  = 2'd2   // remainder beats being emitted
  } bch_phase_e;
endpackage

// File: rtl/bch_lfsr_step.sv
// Combinational D-bit advance of the remainder register: the serial
// divide-by-g(x) step unrolled D times, earliest bit (MSB) first.
module bch_lfsr_step #(
  parameter int            PAR_BITS = 8,
  parameter int            DW       = 2,
  parameter logic [PAR_BITS:0] GEN_POLY = 9'h1D1
) (
  input  logic [PAR_BITS-1:0] rem_in,
  input  logic [DW-1:0]       bits_in,
  output logic [PAR_BITS-1:0] rem_out
);
  localparam logic [PAR_BITS-1:0] TAPS = GEN_POLY[PAR_BITS-1:0];

  logic [PAR_BITS-1:0] acc;
  logic                fb;

  always_comb begin
    acc = rem_in;
    fb  = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      fb  = bits_in[i] ^ acc[PAR_BITS-1];
      acc = (acc << 1) ^ ({PAR_BITS{fb}} & TAPS);
    end
    rem_out = acc;
  end
endmodule

// File: rtl/bch_frame_ctl.sv
// Beat counting and handshake for the message and remainder phases.
module bch_frame_ctl
  import bch_enc_pkg::*;
#(
  parameter int MSG_BEATS = 3,
  parameter int PAR_BEATS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sop,
  input  logic in_eop,
  input  logic slot_free,
  output logic in_ready,
  output logic take_msg,
  output logic first_beat,
  output logic emit_par,
  output logic last_par
);
  localparam int MCW = $clog2(MSG_BEATS + 1);
  localparam int PCW = $clog2(PAR_BEATS + 1);
  localparam logic [MCW-1:0] M_LAST = MCW'(MSG_BEATS - 1);
  localparam logic [PCW-1:0] P_LAST = PCW'(PAR_BEATS - 1);

  bch_phase_e     phase;
  logic [MCW-1:0] mcnt;
  logic [PCW-1:0] pcnt;
  logic           msg_open;
  logic           final_pend;
  logic           accept;
  logic           last_msg;

  assign msg_open   = (phase != PH_PAR);
  assign final_pend = (phase == PH_MSG) && (mcnt == M_LAST);
  assign in_ready   = msg_open && slot_free && !final_pend;
  assign accept     = in_valid && msg_open && slot_free;
  assign take_msg   = accept && ((phase == PH_MSG) || in_sop);
  assign first_beat = (phase == PH_IDLE);
  assign last_msg   = take_msg && final_pend;
  assign emit_par   = (phase == PH_PAR) && slot_free;
  assign last_par   = emit_par && (pcnt == P_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      mcnt  <= '0;
      pcnt  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (take_msg) begin
          phase <= PH_MSG;
          mcnt  <= MCW'(1);
        end
        PH_MSG: if (take_msg) begin
          if (last_msg) begin
            phase <= PH_PAR;
            mcnt  <= '0;
            pcnt  <= '0;
          end else begin
            mcnt <= mcnt + MCW'(1);
          end
        end
        PH_PAR: if (emit_par) begin
          if (last_par) phase <= PH_IDLE;
          else          pcnt  <= pcnt + PCW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: the beat taken as the last of a message must carry the end mark
  a_r3_final_has_eop: assert property (@(posedge clk) disable iff (rst)
    last_msg |-> in_eop);

  // R3: no message beat is taken while remainder beats are pending
  a_r3_closed_in_parity: assert property (@(posedge clk) disable iff (rst)
    (emit_par && !last_par) |=> !in_ready);
endmodule

// File: rtl/bch_stream_enc.sv
// Systematic parallel BCH encoder: message pass-through, then remainder.
module bch_stream_enc #(
  parameter int                PAR_BITS = 8,
  parameter int                MSG_BITS = 6,
  parameter int                DW       = 2,
  parameter logic [PAR_BITS:0] GEN_POLY = 9'h1D1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sop,
  output logic          out_eop,
  output logic [DW-1:0] out_data
);
  localparam int MSG_BEATS = MSG_BITS / DW;
  localparam int PAR_BEATS = PAR_BITS / DW;

  if ((MSG_BITS % DW) != 0) begin : g_bad_msg
    $error("MSG_BITS must be a multiple of DW");
  end
  if ((PAR_BITS % DW) != 0) begin : g_bad_par
    $error("PAR_BITS must be a multiple of DW");
  end
  if (MSG_BEATS < 2) begin : g_bad_width
    $error("DW must be below MSG_BITS");
  end
  if (!GEN_POLY[PAR_BITS] || !GEN_POLY[0]) begin : g_bad_poly
    $error("GEN_POLY needs its top and constant terms set");
  end

  logic                slot_free;
  logic                take_msg;
  logic                first_beat;
  logic                emit_par;
  logic                last_par;
  logic [PAR_BITS-1:0] rem_q;
  logic [PAR_BITS-1:0] rem_base;
  logic [PAR_BITS-1:0] rem_nx;

  assign slot_free = !out_valid || out_ready;
  assign rem_base  = first_beat ? '0 : rem_q;

  bch_frame_ctl #(
    .MSG_BEATS (MSG_BEATS),
    .PAR_BEATS (PAR_BEATS)
  ) i_ctl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .slot_free  (slot_free),
    .in_ready   (in_ready),
    .take_msg   (take_msg),
    .first_beat (first_beat),
    .emit_par   (emit_par),
    .last_par   (last_par)
  );

  bch_lfsr_step #(
    .PAR_BITS (PAR_BITS),
    .DW       (DW),
    .GEN_POLY (GEN_POLY)
  ) i_step (
    .rem_in  (rem_base),
    .bits_in (in_data),
    .rem_out (rem_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q     <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
    end else if (take_msg) begin
      rem_q     <= rem_nx;
      out_data  <= in_data;
      out_valid <= 1'b1;
      out_sop   <= first_beat;
      out_eop   <= 1'b0;
    end else if (emit_par) begin
      out_data  <= rem_q[PAR_BITS-1 -: DW];
      rem_q     <= rem_q << DW;
      out_valid <= 1'b1;
      out_sop   <= 1'b0;
      out_eop   <= last_par;
    end else if (slot_free) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end
  end

  // R5: a stalled beat is held unchanged
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sop) && $stable(out_eop)));

  // R4: after a non-final beat leaves, the next beat is not a start beat
  a_r4_no_sop_midword: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_eop) |=> !out_sop);

  // R4: after a final beat leaves, output is empty or starts a new word
  a_r4_fresh_after_eop: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eop) |=> (!out_valid || out_sop));

  // R7: a start beat taken from idle appears flagged on the next cycle
  a_r7_sop_from_idle: assert property (@(posedge clk) disable iff (rst)
    (take_msg && first_beat) |=> (out_valid && out_sop));
endmodule

// File: tb/test_bch_stream_enc.sv
module test_bch_stream_enc;
  localparam int CLK_PERIOD = 10;
  localparam int R  = 8;
  localparam int K  = 6;
  localparam int D  = 2;
  localparam int MB = K / D;
  localparam int PB = R / D;
  localparam int N  = K + R;
  localparam logic [R:0] G = 9'h1D1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_sop = 1'b0;
  logic         in_eop = 1'b0;
  logic [D-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic         out_sop;
  logic         out_eop;
  logic [D-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bch_stream_enc #(.PAR_BITS(R), .MSG_BITS(K), .DW(D), .GEN_POLY(G)) i_bch_stream_enc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bit-serial reference division, earliest message bit first
  function automatic logic [R-1:0] ref_parity(input logic [K-1:0] m);
    logic [R-1:0] r = '0;
    logic fb;
    for (int i = K - 1; i >= 0; i--) begin
      fb = m[i] ^ r[R-1];
      r  = (r << 1) ^ (fb ? G[R-1:0] : '0);
    end
    return r;
  endfunction

  // long division of a whole received codeword by g(x)
  function automatic bit divisible(input logic [N-1:0] cw);
    logic [R:0] r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      r = {r[R-1:0], cw[i]};
      if (r[R]) r = r ^ G;
    end
    return (r == '0);
  endfunction

  // expected entry: {is_parity, sop, eop, data}
  logic [D+2:0] exp_q[$];
  logic [K-1:0] pkt_q[$];
  logic [K-1:0] cur_msg;
  bit           src_active = 1'b0;
  int           src_beat   = 0;
  bit           in_par     = 1'b0;
  logic [N-1:0] rx_cw      = '0;
  int           words_rx   = 0;
  int           words_tx   = 0;
  bit           stall_seen = 1'b0;
  logic [D+1:0] stall_val;

  task automatic push_expected(input logic [K-1:0] m);
    logic [R-1:0] p = ref_parity(m);
    for (int b = 0; b < MB; b++)
      exp_q.push_back({1'b0, b == 0, 1'b0, m[K-1-b*D -: D]});
    for (int b = 0; b < PB; b++)
      exp_q.push_back({1'b1, 1'b0, b == PB - 1, p[R-1-b*D -: D]});
    words_tx++;
  endtask

  task automatic step(input int valid_pct, input int ready_pct);
    bit offer, free, acc;
    logic [D+2:0] e;
    @(negedge clk);
    if (!src_active && pkt_q.size() > 0) begin
      cur_msg = pkt_q.pop_front();
      src_active = 1'b1;
      src_beat = 0;
    end
    offer     = src_active && (($urandom % 100) < valid_pct);
    in_valid  = offer;
    in_data   = cur_msg[K-1-src_beat*D -: D];
    in_sop    = (src_beat == 0);
    in_eop    = (src_beat == MB - 1);
    out_ready = (($urandom % 100) < ready_pct);
    #1;
    // R5: a beat seen stalled must still be there unchanged
    if (stall_seen)
      check(out_valid && {out_sop, out_eop, out_data} == stall_val, "R5",
            "stalled beat changed", {out_valid, out_sop, out_eop, out_data},
            {1'b1, stall_val});
    stall_seen = out_valid && !out_ready;
    stall_val  = {out_sop, out_eop, out_data};
    free = !out_valid || out_ready;
    if (in_par && out_valid && out_eop) in_par = 1'b0;
    if (in_par)
      check(in_ready == 1'b0, "R3", "ready during parity", in_ready, 0);
    else if (src_active && src_beat == MB - 1)
      check(in_ready == 1'b0, "R3", "ready before final beat", in_ready, 0);
    else
      check(in_ready == free, "R3", "ready vs free output", in_ready, free);
    acc = (src_active && src_beat == MB - 1 && !in_par) ? (offer && free)
                                                       : (offer && in_ready);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected output beat", out_data, 0);
      end else begin
        e = exp_q.pop_front();
        check(out_data == e[D-1:0], e[D+2] ? "R2" : "R1", "beat data",
              out_data, e[D-1:0]);
        check({out_sop, out_eop} == e[D+1:D], "R4", "sop/eop flags",
              {out_sop, out_eop}, e[D+1:D]);
        rx_cw = (rx_cw << D) | N'(out_data);
        if (out_eop) begin
          words_rx++;
          check(divisible(rx_cw), "R2", "codeword not multiple of g", rx_cw, 0);
        end
      end
    end
    if (acc) begin
      if (src_beat == 0) push_expected(cur_msg);
      src_beat++;
      if (src_beat == MB) begin
        src_active = 1'b0;
        in_par = 1'b1;
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (exp_q.size() > 0 || src_active || pkt_q.size() > 0); i++)
      step(100, 100);
  endtask

  initial begin
    bit quiet;
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);

    // R6: a beat without a start mark while idle is dropped
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b0; in_data = 2'b11; out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R6", "stray beat not consumed", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      if (out_valid) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R6", "output after stray beat", !quiet, 0);

    // R7/R2: directed messages sent back to back, sink always ready
    pkt_q.push_back(6'b000000);
    pkt_q.push_back(6'b000001);
    pkt_q.push_back(6'b111111);
    pkt_q.push_back(6'b100000);
    pkt_q.push_back(6'b000001);
    drain();
    check(words_rx == 5, "R7", "back-to-back word count", words_rx, 5);

    // R1..R5: random messages with gaps on both sides
    for (int p = 0; p < 80; p++) pkt_q.push_back(K'($urandom));
    while (pkt_q.size() > 0 || src_active) step(70, 60);
    // R5: heavy sink stalls
    for (int p = 0; p < 20; p++) pkt_q.push_back(K'($urandom));
    while (pkt_q.size() > 0 || src_active) step(90, 20);
    drain();
    check(exp_q.size() == 0, "R2", "beats still owed", exp_q.size(), 0);
    check(words_rx == words_tx, "R2", "words delivered", words_rx, words_tx);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule